// File: doc/BRIEF.md
# Iterative Carry-Loop Adder with Conventional Fallback

This block adds two 32-bit fixed-point operands, a weight and an input sample, by repeated refinement. The first step forms a partial sum (XOR of the operands) and a carry word (AND of the operands moved up one bit). While the carry word is nonzero, each clock cycle runs one more round: the sum becomes sum XOR carry, and the carry becomes (sum AND carry) moved up one bit. Both new values come from the previous pair. When the carry word reaches zero, the partial sum is the result.

The number of rounds is capped, five by default. If the carry is still nonzero after the last allowed round, the block enables a conventional full-width adder on the stored original operands and takes its result instead. At any moment only one of the two paths has its enable raised, which models power gating of the path that is not in use. Bits carried past the top bit are dropped, so both paths give the sum modulo 2^32.

An operand pair is offered with a valid/ready handshake and is taken only while the block is idle. The result comes back as a one-cycle valid pulse. With the result come a path flag and the count of refinement rounds that were used.

Top module: `carry_loop_adder`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. `in_ready` is 1 only while idle, and it drops in the cycle after a pair is accepted.
- R2: `out_sum` equals (`in_a` + `in_b`) modulo 2^32 for the accepted pair, whichever path produced it.
- R3: When the carry word reaches zero after k rounds (0 <= k <= 5), the result has `out_path` = 0 (0 means bitwise) and `out_rounds` = k.
- R4: When (`in_a` AND `in_b`) shifted left by one is zero, the result is valid one cycle after acceptance, with `out_rounds` = 0 and `out_path` = 0.
- R5: When the carry is still nonzero after 5 rounds, `out_path` = 1 (1 means conventional) and `out_rounds` = 5, and the result is valid 7 cycles after acceptance.
- R6: `en_bitwise` and `en_conv` are never high together. Both are low while idle. `en_bitwise` is high exactly in the refinement cycles, and `en_conv` is high only in the single fallback cycle.
- R7: A bitwise result that used k rounds is valid k+1 cycles after acceptance.
- R8: While the block is busy, `in_valid` and the operand inputs have no effect: the result belongs to the pair that was accepted.
- R9: `out_valid` is high for exactly one cycle per accepted pair.
- R10: Overflow wraps with no saturation. For example, 0xFFFFFFFF + 1 gives 0 on the conventional path, and 0x80000000 + 0x80000000 gives 0 on the bitwise path with 0 rounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle, pair will be accepted |
| in_a | input | 32 | Weight operand |
| in_b | input | 32 | Input sample operand |
| out_valid | output | 1 | One-cycle result strobe |
| out_sum | output | 32 | Sum modulo 2^32 |
| out_path | output | 1 | 0 bitwise refinement, 1 conventional adder |
| out_rounds | output | 3 | Refinement rounds used |
| en_bitwise | output | 1 | Refinement path enable |
| en_conv | output | 1 | Conventional path enable |

## Verification
The hardest cases to reach are the edge of the round cap. A pair whose carry dies on exactly the fifth round must stay bitwise, and a pair that needs six rounds must switch over. The stimulus reaches both with a low operand of all ones plus one: 31 + 1 stops on round five, and 63 + 1 falls back. Carries that ripple the full width, and those that leave through the top bit, test the wrap behaviour. A busy-time test keeps `in_valid` high with other operands to show they are ignored.

// File: rtl/cla_pkg.sv
package cla_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOP = 2'd1,
    ST_CONV = 2'd2
  } cla_state_e;
endpackage

// File: rtl/cla_refine_round.sv
// One XOR / AND-shift refinement step; output forced to zero when gated off.
module cla_refine_round #(
  parameter int WIDTH = 32
) (
  input  logic             en,
  input  logic [WIDTH-1:0] sum_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] carry_o
);
  logic [WIDTH-1:0] gen_bits;

  always_comb begin
    gen_bits = sum_i & carry_i;
    if (en) begin
      sum_o   = sum_i ^ carry_i;
      carry_o = {gen_bits[WIDTH-2:0], 1'b0};
    end else begin
      sum_o   = '0;
      carry_o = '0;
    end
  end
endmodule

// File: rtl/cla_fallback_adder.sv
// Conventional full-width adder, output held at zero unless enabled.
module cla_fallback_adder #(
  parameter int WIDTH = 32
) (
  input  logic             en,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum_o
);
  always_comb begin
    sum_o = en ? (a + b) : '0;
  end
endmodule

// File: rtl/cla_sequencer.sv
module cla_sequencer
  import cla_pkg::*;
#(
  parameter int MAX_ROUNDS = 5,
  parameter int CNT_W      = $clog2(MAX_ROUNDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             carry_zero,
  output logic             in_ready,
  output logic             load,
  output logic             step,
  output logic             finish_bit,
  output logic             finish_conv,
  output logic             en_bitwise,
  output logic             en_conv,
  output logic [CNT_W-1:0] rounds
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_ROUNDS);

  cla_state_e state;
  logic       at_cap;

  always_comb begin
    at_cap      = (rounds == CAP);
    in_ready    = (state == ST_IDLE);
    load        = in_ready && in_valid;
    en_bitwise  = (state == ST_LOOP);
    en_conv     = (state == ST_CONV);
    finish_bit  = en_bitwise && carry_zero;
    step        = en_bitwise && !carry_zero && !at_cap;
    finish_conv = en_conv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      rounds <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          state  <= ST_LOOP;
          rounds <= '0;
        end
        ST_LOOP: begin
          if (carry_zero)  state  <= ST_IDLE;
          else if (at_cap) state  <= ST_CONV;
          else             rounds <= rounds + 1'b1;
        end
        ST_CONV: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: ready falls after acceptance
  p_ready_drop_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  // R6: never both paths enabled, none while idle
  p_en_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({en_bitwise, en_conv}) && !(in_ready && (en_bitwise || en_conv)));
  // R5: cap reached with live carry switches to fallback
  p_conv_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (en_bitwise && !carry_zero && rounds == CAP) |=> en_conv);
  // R3: round counter never exceeds cap
  p_rounds_cap_r3: assert property (@(posedge clk) disable iff (rst)
    rounds <= CAP);
endmodule

// File: rtl/carry_loop_adder.sv
module carry_loop_adder
  import cla_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int MAX_ROUNDS = 5,
  parameter int CNT_W      = $clog2(MAX_ROUNDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_path,
  output logic [CNT_W-1:0] out_rounds,
  output logic             en_bitwise,
  output logic             en_conv
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_ROUNDS);

  logic [WIDTH-1:0] op_a, op_b, sum_q, carry_q;
  logic [WIDTH-1:0] rnd_s_in, rnd_c_in, rnd_s_out, rnd_c_out, conv_sum;
  logic             load, step, finish_bit, finish_conv, carry_zero, rnd_en;
  logic [CNT_W-1:0] rounds;

  assign carry_zero = (carry_q == '0);
  assign rnd_en     = load || en_bitwise;

  // The seed step has the same form as a round, applied to the operands.
  always_comb begin
    if (load) begin
      rnd_s_in = in_a;
      rnd_c_in = in_b;
    end else begin
      rnd_s_in = sum_q;
      rnd_c_in = carry_q;
    end
  end

  cla_sequencer #(.MAX_ROUNDS(MAX_ROUNDS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .carry_zero(carry_zero),
    .in_ready(in_ready), .load(load), .step(step), .finish_bit(finish_bit),
    .finish_conv(finish_conv), .en_bitwise(en_bitwise), .en_conv(en_conv),
    .rounds(rounds)
  );

  cla_refine_round #(.WIDTH(WIDTH)) u_round (
    .en(rnd_en), .sum_i(rnd_s_in), .carry_i(rnd_c_in),
    .sum_o(rnd_s_out), .carry_o(rnd_c_out)
  );

  cla_fallback_adder #(.WIDTH(WIDTH)) u_conv (
    .en(en_conv), .a(op_a), .b(op_b), .sum_o(conv_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_a    <= '0;
      op_b    <= '0;
      sum_q   <= '0;
      carry_q <= '0;
    end else if (load) begin
      op_a    <= in_a;
      op_b    <= in_b;
      sum_q   <= rnd_s_out;
      carry_q <= rnd_c_out;
    end else if (step) begin
      sum_q   <= rnd_s_out;
      carry_q <= rnd_c_out;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sum    <= '0;
      out_path   <= 1'b0;
      out_rounds <= '0;
    end else begin
      out_valid <= 1'b0;
      if (finish_bit) begin
        out_valid  <= 1'b1;
        out_sum    <= sum_q;
        out_path   <= 1'b0;
        out_rounds <= rounds;
      end else if (finish_conv) begin
        out_valid  <= 1'b1;
        out_sum    <= conv_sum;
        out_path   <= 1'b1;
        out_rounds <= CAP;
      end
    end
  end

  // R2: sum plus pending carry always equals the true wrapped sum
  p_invariant_r2: assert property (@(posedge clk) disable iff (rst)
    en_bitwise |-> ((sum_q + carry_q) == (op_a + op_b)));
  // R9: result strobe lasts one cycle
  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R5: conventional results report the full round count
  p_conv_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_path) |-> (out_rounds == CAP));
  // R8: stored operands untouched while busy
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> ($stable(op_a) && $stable(op_b)));
endmodule

// File: tb/carry_loop_adder_test.sv
module carry_loop_adder_test;
  localparam int W   = 32;
  localparam int MAX = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_ready;
  logic [W-1:0]  in_a, in_b;
  logic          out_valid;
  logic [W-1:0]  out_sum;
  logic          out_path;
  logic [2:0]    out_rounds;
  logic          en_bitwise, en_conv;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  carry_loop_adder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_sum(out_sum),
    .out_path(out_path), .out_rounds(out_rounds),
    .en_bitwise(en_bitwise), .en_conv(en_conv)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural model from the requirements.
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] s, output bit p, output int r);
    logic [W-1:0] ps, pc, ns;
    ps = a ^ b;
    pc = (a & b) << 1;
    r  = 0;
    while (pc != 0 && r < MAX) begin
      ns = ps ^ pc;
      pc = (ps & pc) << 1;
      ps = ns;
      r++;
    end
    if (pc != 0) begin
      p = 1'b1; s = a + b; r = MAX;
    end else begin
      p = 1'b0; s = ps;
    end
  endtask

  // Offer a pair; optionally keep valid high with junk while busy (R8).
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit junk);
    logic [W-1:0] es;
    bit           ep;
    int           er, lat;
    logic [W:0]   wide;
    model(a, b, es, ep, er);
    wide = {1'b0, a} + {1'b0, b};
    lat  = ep ? MAX + 2 : er + 1;
    @(negedge clk);
    chk("R1 ready before accept", in_ready, 1);
    in_valid = 1'b1; in_a = a; in_b = b;
    for (int k = 1; k <= lat + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        if (junk) begin in_a = ~a; in_b = b + 32'h1234; end
        else in_valid = 1'b0;
      end
      if (k == lat + 1) in_valid = 1'b0;
      chk("R9/R7 out_valid timing", out_valid, (k - 1 == lat));
      chk("R1 in_ready while busy", in_ready, (k - 1 >= lat));
      chk("R6 en_bitwise", en_bitwise, ep ? (k <= MAX + 1) : (k - 1 < lat));
      chk("R6 en_conv", en_conv, ep && (k == MAX + 2));
      if (k - 1 == lat) begin
        chk("R2/R10 sum wraps", out_sum, wide[W-1:0]);
        chk("R2 model sum", out_sum, es);
        chk(ep ? "R5 path" : "R3 path", out_path, ep);
        chk(ep ? "R5 rounds" : "R3 rounds", out_rounds, er);
      end
    end
    @(negedge clk);
    chk("R9 single pulse", out_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset in_ready", in_ready, 1);
    chk("R1 reset out_valid", out_valid, 0);
    chk("R6 reset enables", {en_bitwise, en_conv}, 0);
    run(32'd0, 32'd0, 0);                 // R4
    run(32'd5, 32'd10, 0);                // R4 no shared bits
    run(32'd1, 32'd1, 0);                 // R3 1 round
    run(32'd3, 32'd1, 0);                 // R3 2 rounds
    run(32'd7, 32'd1, 0);                 // R7 3 rounds
    run(32'd15, 32'd1, 0);                // R7 4 rounds
    run(32'd31, 32'd1, 0);                // R3 exactly at cap
    run(32'd63, 32'd1, 0);                // R5 one past cap
    run(32'hFFFF_FFFF, 32'd1, 0);         // R10 conventional wrap
    run(32'h8000_0000, 32'h8000_0000, 0); // R10 bitwise wrap
    run(32'h0000_00FF, 32'h0000_0001, 1); // R8 busy junk ignored
    run(32'h1234_5678, 32'h0F0F_0F0F, 1); // R8
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 3 == 0) rb = rb & 32'h0000_00FF;
      run(ra, rb, (i % 4) == 1);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule